// File: doc/BRIEF.md
# Branch Condition and Loop-Counter Unit

This unit resolves the conditional branches of a small 16-bit processor with a 24-bit program counter. The execute stage gives it one instruction per cycle: the 6-bit opcode, a selector for a flag or bit, up to two register operands, the current flag vector, the bit-addressable register, the current program counter, the already resolved branch target and the instruction length in words. One cycle later the unit returns whether the branch is taken, the next program counter, an optional register write-back and an optional update of the carry, zero and negative flags.

There are four families of branches. Flag tests and bit tests look at one selected bit and branch on either polarity. Loop branches test a register against zero and, when they do not branch, decrement that register. Compare branches compare two registers, unsigned. Bit tests load the whole program counter. Every other branch replaces only the low local part and keeps the upper page. The target address computation and the fetch redirection happen elsewhere.

Top module: `branch_cond_unit`

## Requirements
- R1: While rst_ni is low, and on the first sample after reset, every output is zero.
- R2: Opcode 6'b100000 is taken when flags_i[sel_i] is 0. Opcode 6'b100001 is taken when flags_i[sel_i] is 1.
- R3: Opcode 6'b100010 is taken when r08_i[sel_i] is 0. Opcode 6'b100011 is taken when r08_i[sel_i] is 1.
- R4: A taken bit-test branch sets next_pc_o to all 24 bits of target_i.
- R5: A taken flag-test, loop or compare branch sets next_pc_o to {pc_i[23:16], target_i[15:0]}.
- R6: A branch that is not taken, and any opcode outside 6'b100000..6'b101001, sets next_pc_o to (pc_i + ilen_i) modulo 2^24, with taken_o low.
- R7: Opcode 6'b100100 is taken when rs_i is zero. Otherwise it raises wb_en_o with wb_data_o = rs_i - 1.
- R8: Opcode 6'b100101 is taken when rs_i is nonzero. Otherwise it raises wb_en_o with wb_data_o = rs_i - 1, which is 16'hFFFF.
- R9: Both loop opcodes raise flag_we_o whether taken or not, with C = (rs_i == 0), Z = (rs_i == 1) and N = bit 15 of rs_i - 1.
- R10: Opcodes 6'b100110, 6'b100111, 6'b101000 and 6'b101001 are taken when rs_i == rs2_i, rs_i != rs2_i, rs_i > rs2_i and rs_i >= rs2_i, all unsigned.
- R11: Compare opcodes raise flag_we_o with C = (rs_i < rs2_i) unsigned, Z = (rs_i == rs2_i) and N = bit 15 of rs_i - rs2_i.
- R12: Flag-test branches, bit-test branches and non-branch opcodes keep flag_we_o and wb_en_o low.
- R13: The outputs show the instruction sampled at the previous clock edge. out_valid_o follows valid_i by one cycle. While out_valid_o is low, taken_o, wb_en_o and flag_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present |
| opcode_i | input | 6 | Instruction opcode |
| sel_i | input | 4 | Flag or bit index |
| rs_i | input | 16 | First register operand |
| rs2_i | input | 16 | Second register operand |
| flags_i | input | 16 | Current flag vector |
| r08_i | input | 16 | Bit-addressable register |
| pc_i | input | 24 | Current program counter |
| target_i | input | 24 | Resolved branch target |
| ilen_i | input | 2 | Instruction length in words |
| out_valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 24 | Next program counter |
| wb_en_o | output | 1 | Register write-back enable |
| wb_data_o | output | 16 | Write-back value |
| flag_we_o | output | 1 | Flag update enable |
| flag_c_o | output | 1 | Carry flag value |
| flag_z_o | output | 1 | Zero flag value |
| flag_n_o | output | 1 | Negative flag value |

## Verification
The hardest cases to reach are at the edges of the loop counter: rs_i equal to 0 or 1 under both loop opcodes, where the borrow, the zero flag and the 16'hFFFF write-back all change at once. Compare operands that differ only in bit 15 are equally hard to reach. Random operands almost never land there, so the bench forces operand values from a short list of corner values on a large share of the cycles. It also runs a program counter near 24'hFFFFFF so that the local-page and wrap behaviour can be seen.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_FLAG = 3'd1,
    CLS_BIT  = 3'd2,
    CLS_DEC  = 3'd3,
    CLS_CMP  = 3'd4
  } br_cls_e;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_GT = 2'd2,
    CMP_GE = 2'd3
  } cmp_kind_e;

  localparam logic [5:0] OP_FLAG0 = 6'b100000;
  localparam logic [5:0] OP_FLAG1 = 6'b100001;
  localparam logic [5:0] OP_BIT0  = 6'b100010;
  localparam logic [5:0] OP_BIT1  = 6'b100011;
  localparam logic [5:0] OP_DECZ  = 6'b100100;
  localparam logic [5:0] OP_DECNZ = 6'b100101;
  localparam logic [5:0] OP_CMPEQ = 6'b100110;
  localparam logic [5:0] OP_CMPNE = 6'b100111;
  localparam logic [5:0] OP_CMPGT = 6'b101000;
  localparam logic [5:0] OP_CMPGE = 6'b101001;
endpackage

// File: rtl/bcu_decode.sv
module bcu_decode
  import bcu_pkg::*;
(
  input  logic [5:0] opcode_i,
  output br_cls_e    cls_o,
  output logic       pol_o,
  output cmp_kind_e  cmp_o
);
  always_comb begin
    cls_o = CLS_NONE;
    pol_o = opcode_i[0];
    cmp_o = CMP_EQ;
    unique case (opcode_i)
      OP_FLAG0, OP_FLAG1: cls_o = CLS_FLAG;
      OP_BIT0,  OP_BIT1:  cls_o = CLS_BIT;
      OP_DECZ,  OP_DECNZ: cls_o = CLS_DEC;
      OP_CMPEQ: begin cls_o = CLS_CMP; cmp_o = CMP_EQ; end
      OP_CMPNE: begin cls_o = CLS_CMP; cmp_o = CMP_NE; end
      OP_CMPGT: begin cls_o = CLS_CMP; cmp_o = CMP_GT; end
      OP_CMPGE: begin cls_o = CLS_CMP; cmp_o = CMP_GE; end
      default:  cls_o = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/bcu_cond.sv
module bcu_cond
  import bcu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned SEL_W = $clog2(DATA_W)
) (
  input  br_cls_e           cls_i,
  input  logic              pol_i,
  input  cmp_kind_e         cmp_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rs2_i,
  input  logic [DATA_W-1:0] flags_i,
  input  logic [DATA_W-1:0] bits_i,
  output logic              cond_o,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              flag_we_o,
  output logic              c_o,
  output logic              z_o,
  output logic              n_o
);
  logic [DATA_W:0] diff;
  logic [DATA_W:0] dec;
  logic            rs_zero, eq, lt, tested;

  // one extra bit holds the borrow
  assign diff    = {1'b0, rs_i} - {1'b0, rs2_i};
  assign dec     = {1'b0, rs_i} - {{DATA_W{1'b0}}, 1'b1};
  assign rs_zero = (rs_i == '0);
  assign eq      = (diff[DATA_W-1:0] == '0);
  assign lt      = diff[DATA_W];
  assign tested  = (cls_i == CLS_BIT) ? bits_i[sel_i] : flags_i[sel_i];

  always_comb begin
    cond_o    = 1'b0;
    wb_en_o   = 1'b0;
    wb_data_o = '0;
    flag_we_o = 1'b0;
    c_o       = 1'b0;
    z_o       = 1'b0;
    n_o       = 1'b0;
    unique case (cls_i)
      CLS_FLAG, CLS_BIT: cond_o = pol_i ? tested : !tested;
      CLS_DEC: begin
        cond_o    = pol_i ? !rs_zero : rs_zero;
        wb_en_o   = !cond_o;
        wb_data_o = dec[DATA_W-1:0];
        flag_we_o = 1'b1;
        c_o       = dec[DATA_W];
        z_o       = (dec[DATA_W-1:0] == '0);
        n_o       = dec[DATA_W-1];
      end
      CLS_CMP: begin
        unique case (cmp_i)
          CMP_EQ: cond_o = eq;
          CMP_NE: cond_o = !eq;
          CMP_GT: cond_o = !lt && !eq;
          CMP_GE: cond_o = !lt;
          default: cond_o = 1'b0;
        endcase
        flag_we_o = 1'b1;
        c_o       = lt;
        z_o       = eq;
        n_o       = diff[DATA_W-1];
      end
      default: cond_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcu_pc.sv
module bcu_pc #(
  parameter int unsigned PC_W    = 24,
  parameter int unsigned LOCAL_W = 16,
  parameter int unsigned LEN_W   = 2
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  target_i,
  input  logic [LEN_W-1:0] ilen_i,
  input  logic             taken_i,
  input  logic             full_i,
  output logic [PC_W-1:0]  next_pc_o
);
  logic [PC_W-1:0] seq_pc, local_pc;

  assign seq_pc = pc_i + {{(PC_W-LEN_W){1'b0}}, ilen_i};

  generate
    if (LOCAL_W < PC_W) begin : g_paged
      assign local_pc = {pc_i[PC_W-1:LOCAL_W], target_i[LOCAL_W-1:0]};
    end else begin : g_flat
      assign local_pc = target_i;
    end
  endgenerate

  always_comb begin
    if (!taken_i)    next_pc_o = seq_pc;
    else if (full_i) next_pc_o = target_i;
    else             next_pc_o = local_pc;
  end
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
  import bcu_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PC_W    = 24,
  parameter int unsigned LOCAL_W = 16,
  parameter int unsigned LEN_W   = 2,
  localparam int unsigned SEL_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [5:0]        opcode_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rs2_i,
  input  logic [DATA_W-1:0] flags_i,
  input  logic [DATA_W-1:0] r08_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   target_i,
  input  logic [LEN_W-1:0]  ilen_i,
  output logic              out_valid_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              flag_we_o,
  output logic              flag_c_o,
  output logic              flag_z_o,
  output logic              flag_n_o
);
  br_cls_e           cls;
  cmp_kind_e         cmp;
  logic              pol, cond, wb_en, flag_we, c, z, n;
  logic [DATA_W-1:0] wb_data;
  logic [PC_W-1:0]   npc;

  bcu_decode u_dec (
    .opcode_i (opcode_i),
    .cls_o    (cls),
    .pol_o    (pol),
    .cmp_o    (cmp)
  );

  bcu_cond #(.DATA_W(DATA_W)) u_cond (
    .cls_i     (cls),
    .pol_i     (pol),
    .cmp_i     (cmp),
    .sel_i     (sel_i),
    .rs_i      (rs_i),
    .rs2_i     (rs2_i),
    .flags_i   (flags_i),
    .bits_i    (r08_i),
    .cond_o    (cond),
    .wb_en_o   (wb_en),
    .wb_data_o (wb_data),
    .flag_we_o (flag_we),
    .c_o       (c),
    .z_o       (z),
    .n_o       (n)
  );

  bcu_pc #(.PC_W(PC_W), .LOCAL_W(LOCAL_W), .LEN_W(LEN_W)) u_pc (
    .pc_i      (pc_i),
    .target_i  (target_i),
    .ilen_i    (ilen_i),
    .taken_i   (cond),
    .full_i    (cls == CLS_BIT),
    .next_pc_o (npc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      taken_o     <= 1'b0;
      next_pc_o   <= '0;
      wb_en_o     <= 1'b0;
      wb_data_o   <= '0;
      flag_we_o   <= 1'b0;
      flag_c_o    <= 1'b0;
      flag_z_o    <= 1'b0;
      flag_n_o    <= 1'b0;
    end else begin
      out_valid_o <= valid_i;
      taken_o     <= valid_i && cond;
      next_pc_o   <= npc;
      wb_en_o     <= valid_i && wb_en;
      wb_data_o   <= wb_data;
      flag_we_o   <= valid_i && flag_we;
      flag_c_o    <= c;
      flag_z_o    <= z;
      flag_n_o    <= n;
    end
  end
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PC_W    = 24,
  parameter int unsigned LOCAL_W = 16,
  parameter int unsigned LEN_W   = 2,
  localparam int unsigned SEL_W  = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [5:0]        opcode_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [PC_W-1:0]   target_i,
  input logic [LEN_W-1:0]  ilen_i,
  input logic              out_valid_o,
  input logic              taken_o,
  input logic [PC_W-1:0]   next_pc_o,
  input logic              wb_en_o,
  input logic              flag_we_o
);
  a_r13_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> out_valid_o);
  a_r13_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !out_valid_o);
  a_r13_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (!taken_o && !wb_en_o && !flag_we_o));
  a_r6_seq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !taken_o) |->
      next_pc_o == $past(pc_i) + {{(PC_W-LEN_W){1'b0}}, $past(ilen_i)});
  a_r4_full_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && $past(opcode_i[5:1]) == 5'b10001) |-> next_pc_o == $past(target_i));
  a_r5_local_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && $past(opcode_i[5:1]) != 5'b10001) |->
      next_pc_o[LOCAL_W-1:0] == $past(target_i[LOCAL_W-1:0]));
  a_r7_wb_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> !taken_o);
  a_r12_flag_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> ($past(opcode_i) >= 6'b100100 && $past(opcode_i) <= 6'b101001));
endmodule

bind branch_cond_unit bcu_checker #(
  .DATA_W(DATA_W), .PC_W(PC_W), .LOCAL_W(LOCAL_W), .LEN_W(LEN_W)
) u_bcu_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .opcode_i    (opcode_i),
  .pc_i        (pc_i),
  .target_i    (target_i),
  .ilen_i      (ilen_i),
  .out_valid_o (out_valid_o),
  .taken_o     (taken_o),
  .next_pc_o   (next_pc_o),
  .wb_en_o     (wb_en_o),
  .flag_we_o   (flag_we_o)
);

// File: tb/branch_cond_unit_bench.sv
`timescale 1ns/1ps
module branch_cond_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [5:0]  op = '0;
  logic [3:0]  sel = '0;
  logic [15:0] rs = '0, rs2 = '0, flg = '0, r08 = '0;
  logic [23:0] pc = '0, tgt = '0;
  logic [1:0]  len = '0;

  logic        o_valid, o_taken, o_wb_en, o_fwe, o_c, o_z, o_n;
  logic [23:0] o_npc;
  logic [15:0] o_wb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  branch_cond_unit u_branch_cond_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opcode_i(op), .sel_i(sel),
    .rs_i(rs), .rs2_i(rs2), .flags_i(flg), .r08_i(r08), .pc_i(pc),
    .target_i(tgt), .ilen_i(len), .out_valid_o(o_valid), .taken_o(o_taken),
    .next_pc_o(o_npc), .wb_en_o(o_wb_en), .wb_data_o(o_wb), .flag_we_o(o_fwe),
    .flag_c_o(o_c), .flag_z_o(o_z), .flag_n_o(o_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one instruction at a falling edge, compare one cycle later.
  task automatic step(input bit v, input int o, input int s, input int a, input int b,
                      input int f, input int r, input int p, input int t, input int l);
    int e_taken, e_wb_en, e_wb, e_fwe, e_c, e_z, e_n, e_npc, bitv, d;
    string rq_t, rq_f;
    valid = v; op = 6'(o); sel = 4'(s); rs = 16'(a); rs2 = 16'(b);
    flg = 16'(f); r08 = 16'(r); pc = 24'(p); tgt = 24'(t); len = 2'(l);
    e_taken = 0; e_wb_en = 0; e_wb = -1; e_fwe = 0; e_c = 0; e_z = 0; e_n = 0;
    rq_t = "R6"; rq_f = "R12";
    if (o == 32 || o == 33) begin
      bitv = (f >> s) & 1; e_taken = (o == 33) ? bitv : !bitv; rq_t = "R2";
    end else if (o == 34 || o == 35) begin
      bitv = (r >> s) & 1; e_taken = (o == 35) ? bitv : !bitv; rq_t = "R3";
    end else if (o == 36 || o == 37) begin
      a = a & 16'hFFFF;
      e_taken = (o == 36) ? (a == 0) : (a != 0);
      rq_t = (o == 36) ? "R7" : "R8"; rq_f = "R9";
      e_wb_en = !e_taken; e_wb = (a - 1) & 16'hFFFF;
      e_fwe = 1; e_c = (a == 0); e_z = (a == 1); e_n = ((a - 1) >> 15) & 1;
    end else if (o >= 38 && o <= 41) begin
      a = a & 16'hFFFF; b = b & 16'hFFFF;
      case (o)
        38: e_taken = (a == b);
        39: e_taken = (a != b);
        40: e_taken = (a > b);
        default: e_taken = (a >= b);
      endcase
      rq_t = "R10"; rq_f = "R11";
      d = a - b;
      e_fwe = 1; e_c = (a < b); e_z = (a == b); e_n = (d >> 15) & 1;
    end
    if (!v) begin e_taken = 0; e_wb_en = 0; e_fwe = 0; end
    if (!e_taken) e_npc = (p + l) & 24'hFFFFFF;
    else if (o == 34 || o == 35) e_npc = t & 24'hFFFFFF;
    else e_npc = (p & 24'hFF0000) | (t & 16'hFFFF);
    @(negedge clk);
    chk(o_valid == v, "R13", "out_valid", o_valid, v);
    chk(o_taken == e_taken, v ? rq_t : "R13", "taken", o_taken, e_taken);
    if (v) begin
      chk(o_npc == 24'(e_npc), !e_taken ? "R6" : ((o == 34 || o == 35) ? "R4" : "R5"),
          "next_pc", o_npc, e_npc);
      chk(o_fwe == e_fwe, rq_f, "flag_we", o_fwe, e_fwe);
      if (e_fwe) chk({o_c, o_z, o_n} == 3'({e_c[0], e_z[0], e_n[0]}), rq_f, "czn",
                     {o_c, o_z, o_n}, {e_c[0], e_z[0], e_n[0]});
      chk(o_wb_en == e_wb_en, (o == 36 || o == 37) ? rq_t : "R12", "wb_en", o_wb_en, e_wb_en);
      if (e_wb_en) chk(o_wb == 16'(e_wb), rq_t, "wb_data", o_wb, e_wb);
    end else begin
      chk(!o_wb_en && !o_fwe, "R13", "idle enables", {o_wb_en, o_fwe}, 0);
    end
  endtask

  function automatic int pick16();
    int k = $urandom_range(0, 7);
    case (k)
      0: return 0;
      1: return 1;
      2: return 16'hFFFF;
      3: return 16'h8000;
      4: return 16'h7FFF;
      default: return $urandom_range(0, 16'hFFFF);
    endcase
  endfunction

  initial begin
    #1 chk(!o_valid && !o_taken && o_npc == 0 && !o_wb_en && !o_fwe && o_wb == 0,
           "R1", "reset outputs", {o_valid, o_taken, o_wb_en, o_fwe}, 0);
    #30;
    @(negedge clk);
    rst_n = 1'b1;
    chk(!o_valid && o_npc == 0, "R1", "after release", o_npc, 0);
    // R2 flag tests
    step(1, 32, 3, 0, 0, 16'h0000, 0, 24'h120010, 24'h00ABCD, 1);
    step(1, 32, 3, 0, 0, 16'h0008, 0, 24'h120010, 24'h00ABCD, 1);
    step(1, 33, 15, 0, 0, 16'h8000, 0, 24'h340000, 24'h771234, 2);
    // R3 / R4 bit tests with full load
    step(1, 34, 0, 0, 0, 0, 16'hFFFE, 24'h120010, 24'h9A5555, 1);
    step(1, 35, 7, 0, 0, 0, 16'h0080, 24'h120010, 24'h9A5555, 2);
    step(1, 35, 7, 0, 0, 16'hFFFF, 16'h0000, 24'h120010, 24'h9A5555, 2);
    // R7 / R8 / R9 loop edges
    step(1, 36, 0, 0, 0, 0, 0, 24'h010000, 24'h000100, 2);
    step(1, 36, 0, 1, 0, 0, 0, 24'h010000, 24'h000100, 2);
    step(1, 36, 0, 16'h8000, 0, 0, 0, 24'h010000, 24'h000100, 2);
    step(1, 37, 0, 0, 0, 0, 0, 24'h010000, 24'h000100, 2);
    step(1, 37, 0, 1, 0, 0, 0, 24'h010000, 24'h000100, 2);
    // R10 / R11 compares around bit 15
    step(1, 38, 0, 16'h8000, 16'h8000, 0, 0, 24'h050000, 24'hFF4321, 3);
    step(1, 39, 0, 16'h8000, 16'h0000, 0, 0, 24'h050000, 24'hFF4321, 3);
    step(1, 40, 0, 16'h8000, 16'h7FFF, 0, 0, 24'h050000, 24'hFF4321, 3);
    step(1, 40, 0, 16'h7FFF, 16'h8000, 0, 0, 24'h050000, 24'hFF4321, 3);
    step(1, 41, 0, 16'h1234, 16'h1234, 0, 0, 24'h050000, 24'hFF4321, 3);
    // R6 wrap and non-branch opcodes
    step(1, 2, 0, 0, 0, 0, 0, 24'hFFFFFF, 24'h000000, 3);
    step(1, 42, 0, 0, 0, 0, 0, 24'h00FFFE, 24'h123456, 2);
    // R13 idle cycle with a branch that would be taken
    step(0, 36, 0, 0, 0, 0, 0, 24'h000000, 24'h00FFFF, 1);
    for (int i = 0; i < 600; i++) begin
      int o = $urandom_range(0, 3) == 0 ? $urandom_range(0, 63) : $urandom_range(32, 41);
      step($urandom_range(0, 7) != 0, o, $urandom_range(0, 15), pick16(), pick16(),
           $urandom_range(0, 16'hFFFF), $urandom_range(0, 16'hFFFF),
           $urandom_range(0, 24'hFFFFFF), $urandom_range(0, 24'hFFFFFF),
           $urandom_range(0, 3));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule